// File: doc/BRIEF.md
# SPI Flash Auto-Boot Streaming Responder

This block sits on the device side of a serial NOR flash. It lets a host read boot code with no command phase. After every reset it is armed once. On the first chip-select assertion it sends no opcode and takes no address. It waits a programmable number of SCK cycles and then streams bytes from a configured start address. The bytes go out one bit per clock on SO, or four bits per clock on all four IO lanes. The stream continues until chip select is released. The block then raises a handoff flag so that the normal command decoder owns the interface until the next reset.

SCK and CS# are sampled on the internal clock `clk_i` through a two-stage synchronizer. Data advances on each detected falling SCK edge, so a host that samples on rising SCK edges sees stable data. Bytes come from a synchronous byte-read port: data returns one `clk_i` cycle after a read strobe. The next byte is fetched while the last bit or nibble of the current byte is on the pins, so successive bytes leave without a gap. Tri-state is expressed through per-lane output-enable signals.

Top module: `ab_boot_top`

## Requirements
- R1: With `cfg_en_i` low, no stream occurs after reset. `handoff_o` is high once reset is released. `io_oe_o` stays 0 and no memory read is issued on a chip-select assertion.
- R2: The first streamed byte is read from byte address `cfg_start_i` × 512, truncated to `ADDR_W` bits.
- R3: After CS# falls, `io_oe_o` is 0 for the first `cfg_delay_i` rising SCK edges. The first data bit is valid at rising edge `cfg_delay_i`+1, so a value of 0 means no wait. SI has no effect on any output.
- R4: With `cfg_quad_i` at 0, each byte is driven on lane 1 (`io_o[1]`), MSB first, one bit per SCK cycle. `io_oe_o` is 4'b0010 in this mode.
- R5: With `cfg_quad_i` at 1, each byte is driven on `io_o[3:0]`, upper nibble first, then lower nibble. `io_oe_o` is 4'b1111 in this mode.
- R6: Bytes follow one another from consecutive addresses, with no idle SCK cycle between them, for as long as CS# is low.
- R7: The byte address wraps from 2^`ADDR_W`−1 to 0.
- R8: When CS# rises, the block stops driving (`io_oe_o` = 0) and raises `handoff_o`. This holds also when the rise comes mid-byte or during the wait.
- R9: Once `handoff_o` is high it stays high until reset. Later CS# assertions drive nothing and issue no memory read.
- R10: Reset re-arms the block: `handoff_o` is low after reset when enabled, and the next CS# assertion streams again.
- R11: Output lanes change only after a falling SCK edge. They are stable through the high phase of SCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset (arms auto-boot) |
| sck_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial input from host (ignored during boot) |
| cfg_en_i | input | 1 | Auto-boot enable |
| cfg_start_i | input | 23 | Start address in 512-byte units |
| cfg_delay_i | input | 8 | SCK cycles to wait before data |
| cfg_quad_i | input | 1 | 1: four lanes, 0: single lane |
| mem_addr_o | output | ADDR_W | Byte read address |
| mem_rd_o | output | 1 | Read strobe, data on `mem_data_i` next cycle |
| mem_data_i | input | 8 | Read data |
| io_o | output | 4 | Output lane values |
| io_oe_o | output | 4 | Per-lane output enable |
| handoff_o | output | 1 | Interface released to command decoder |

## Verification
Two functions can fall in the same SCK falling edge: the byte-boundary reload of the shifter from the prefetch buffer, and the release triggered by CS# rising. The bench raises CS# at arbitrary points: mid-byte after 2 bytes and 3 bits, during the wait, and right after a byte. It judges at the pins that lanes go undriven and `handoff_o` rises, with no further memory reads. The other coincidence is SI toggling on the very edge where data shifts. The bench drives random SI on every falling edge. It compares every rising-edge sample against a behavioural stream model, so any influence of SI shows up as a data mismatch.

// File: rtl/ab_boot_pkg.sv
package ab_boot_pkg;
  localparam int unsigned START_W     = 23;
  localparam int unsigned ALIGN_SHIFT = 9;
  localparam int unsigned DLY_W       = 8;
  localparam int unsigned FULL_W      = START_W + ALIGN_SHIFT;

  typedef enum logic [1:0] {
    ST_ARMED,
    ST_WAIT,
    ST_SHIFT,
    ST_DONE
  } ab_state_e;
endpackage

// File: rtl/ab_pin_sync.sv
module ab_pin_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] lvl_d_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [2:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= {3{RST_VAL[g]}};
      else         q <= {q[1:0], d_i[g]};
    end
    assign lvl_o[g]   = q[1];
    assign lvl_d_o[g] = q[2];
    assign rise_o[g]  = q[1] & ~q[2];
    assign fall_o[g]  = ~q[1] & q[2];
  end
endmodule

// File: rtl/ab_boot_shifter.sv
module ab_boot_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       adv_i,
  input  logic       quad_i,
  input  logic [7:0] data_i,
  output logic [3:0] lanes_o,
  output logic       pre_last_o,
  output logic       last_o
);
  logic [7:0] sh_q;
  logic [2:0] cnt_q;

  assign last_o     = quad_i ? (cnt_q == 3'd1) : (cnt_q == 3'd7);
  assign pre_last_o = quad_i ? (cnt_q == 3'd0) : (cnt_q == 3'd6);
  assign lanes_o    = quad_i ? sh_q[7:4] : {2'b00, sh_q[7], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i || (adv_i && last_o)) begin
      sh_q  <= data_i;
      cnt_q <= '0;
    end else if (adv_i) begin
      sh_q  <= quad_i ? {sh_q[3:0], 4'b0000} : {sh_q[6:0], 1'b0};
      cnt_q <= cnt_q + 3'd1;
    end
  end
endmodule

// File: rtl/ab_boot_top.sv
module ab_boot_top
  import ab_boot_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               cs_ni,
  input  logic               si_i,
  input  logic               cfg_en_i,
  input  logic [START_W-1:0] cfg_start_i,
  input  logic [DLY_W-1:0]   cfg_delay_i,
  input  logic               cfg_quad_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_rd_o,
  input  logic [7:0]         mem_data_i,
  output logic [3:0]         io_o,
  output logic [3:0]         io_oe_o,
  output logic               handoff_o
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [1:0] pin_lvl, pin_lvl_d, pin_rise, pin_fall;
  ab_pin_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i}),
    .lvl_o  (pin_lvl),
    .lvl_d_o(pin_lvl_d),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  logic sck_fall, cs_fall, cs_rise, cs_hi_d;
  assign sck_fall = pin_fall[0];
  assign cs_fall  = pin_fall[1];
  assign cs_rise  = pin_rise[1];
  assign cs_hi_d  = pin_lvl_d[1];

  logic [FULL_W-1:0] start_full;
  logic [ADDR_W-1:0] start_addr;
  assign start_full = {cfg_start_i, {ALIGN_SHIFT{1'b0}}};
  assign start_addr = start_full[ADDR_W-1:0];

  logic unused_ok;
  assign unused_ok = ^{si_i, start_full[FULL_W-1:ADDR_W], pin_lvl, pin_lvl_d[0], pin_rise[0]};

  ab_state_e         state_q;
  logic [DLY_W-1:0]  dly_q;
  logic              quad_q;
  logic [ADDR_W-1:0] next_addr_q, rd_addr_q;
  logic              rd_q, rd_d_q, buf_vld_q;
  logic [7:0]        buf_q;

  logic go_shift, adv, pre_last, last;
  logic [3:0] lanes;

  assign go_shift = (state_q == ST_WAIT) && !cs_rise && (dly_q == '0) && buf_vld_q;
  assign adv      = (state_q == ST_SHIFT) && sck_fall && !cs_rise;

  ab_boot_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (go_shift),
    .adv_i     (adv),
    .quad_i    (quad_q),
    .data_i    (buf_q),
    .lanes_o   (lanes),
    .pre_last_o(pre_last),
    .last_o    (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_ARMED;
      dly_q       <= '0;
      quad_q      <= 1'b0;
      next_addr_q <= '0;
      rd_addr_q   <= '0;
      rd_q        <= 1'b0;
    end else begin
      rd_q <= 1'b0;
      unique case (state_q)
        ST_ARMED: begin
          if (!cfg_en_i) begin
            state_q <= ST_DONE;
          end else if (cs_fall) begin
            quad_q      <= cfg_quad_i;
            dly_q       <= cfg_delay_i;
            rd_addr_q   <= start_addr;
            next_addr_q <= start_addr + ADDR_ONE;
            rd_q        <= 1'b1;
            state_q     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cs_rise)                     state_q <= ST_DONE;
          else if (go_shift)               state_q <= ST_SHIFT;
          else if (sck_fall && dly_q != '0) dly_q  <= dly_q - 1'b1;
        end
        ST_SHIFT: begin
          if (cs_rise) begin
            state_q <= ST_DONE;
          end else if (adv && pre_last) begin
            // prefetch while the final bit or nibble is on the pins
            rd_addr_q   <= next_addr_q;
            next_addr_q <= next_addr_q + ADDR_ONE;
            rd_q        <= 1'b1;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_d_q    <= 1'b0;
      buf_q     <= '0;
      buf_vld_q <= 1'b0;
    end else begin
      rd_d_q <= rd_q;
      if (rd_q)        buf_vld_q <= 1'b0;
      else if (rd_d_q) buf_vld_q <= 1'b1;
      if (rd_d_q)      buf_q     <= mem_data_i;
    end
  end

  logic unused_last;
  assign unused_last = last;

  assign mem_addr_o = rd_addr_q;
  assign mem_rd_o   = rd_q;
  assign handoff_o  = (state_q == ST_DONE);
  assign io_o       = (state_q == ST_SHIFT) ? lanes : 4'b0000;
  assign io_oe_o    = (state_q != ST_SHIFT) ? 4'b0000 : (quad_q ? 4'b1111 : 4'b0010);
endmodule

// File: rtl/ab_boot_chk.sv
module ab_boot_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sck_fall_i,
  input logic       cs_hi_i,
  input logic [3:0] io_o,
  input logic [3:0] io_oe_o,
  input logic       mem_rd_o,
  input logic       handoff_o
);
  p_oe_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o == 4'b0000) || (io_oe_o == 4'b0010) || (io_oe_o == 4'b1111));

  p_handoff_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handoff_o |=> handoff_o);

  p_quiet_after_handoff_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handoff_o |-> (io_oe_o == 4'b0000) && !mem_rd_o);

  p_released_cs_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_i |-> (io_oe_o == 4'b0000));

  p_stable_between_falls_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(sck_fall_i) && ($past(io_oe_o) != 4'b0000) && (io_oe_o != 4'b0000)) |-> $stable(io_o));

  p_single_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
endmodule

bind ab_boot_top ab_boot_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sck_fall_i(sck_fall),
  .cs_hi_i   (cs_hi_d),
  .io_o      (io_o),
  .io_oe_o   (io_oe_o),
  .mem_rd_o  (mem_rd_o),
  .handoff_o (handoff_o)
);

// File: tb/tb_ab_boot_top.sv
module tb_ab_boot_top;
  logic        clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic        en = 1'b1, quad = 1'b0;
  logic [22:0] sfield = '0;
  logic [7:0]  dly = '0;
  logic [23:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_q = '0;
  logic [3:0]  io, oe;
  logic        handoff;
  int checks = 0, fails = 0, rd_cnt = 0;

  always #5 clk = ~clk;

  ab_boot_top dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .cfg_en_i(en), .cfg_start_i(sfield), .cfg_delay_i(dly), .cfg_quad_i(quad),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_data_i(mem_q),
    .io_o(io), .io_oe_o(oe), .handoff_o(handoff)
  );

  function automatic logic [7:0] pat(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[22:16], a[23]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_q  <= pat(mem_addr);
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit enable);
    cs_n = 1'b1; sck = 1'b0; en = enable;
    rst_n = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(6);
    chk(handoff == !enable, enable ? "R10" : "R1", {7'd0, handoff}, {7'd0, !enable});
    chk(oe == 4'b0000, "R8", {4'd0, oe}, 8'h00);
  endtask

  // one chip-select session of nedges SCK cycles, compared edge by edge
  task automatic session(input bit armed, input int fld, input int d, input bit q, input int nedges,
                         input string idle_tag);
    int rd0;
    sfield = 23'(fld); dly = 8'(d); quad = q;
    rd0 = rd_cnt;
    cs_n = 1'b0;
    wait_n(12);
    for (int k = 1; k <= nedges; k++) begin
      logic [3:0] e_oe, e_io, mask;
      string tag;
      e_oe = 4'b0000; e_io = 4'b0000; mask = 4'b0000; tag = idle_tag;
      if (armed && k > d) begin
        int j, bpb, b, s;
        logic [23:0] a;
        logic [7:0]  byte_v;
        j = k - d - 1; bpb = q ? 2 : 8; b = j / bpb; s = j % bpb;
        a = 24'((fld << 9) + b);
        byte_v = pat(a);
        if (q) begin
          e_oe = 4'b1111; mask = 4'b1111;
          e_io = (s == 0) ? byte_v[7:4] : byte_v[3:0];
        end else begin
          e_oe = 4'b0010; mask = 4'b0010;
          e_io = {2'b00, byte_v[7 - s], 1'b0};
        end
        if (b == 0)                          tag = "R2";
        else if ((fld << 9) + b >= 24'hFFFFFF + 1) tag = "R7";
        else if (b == 1)                     tag = q ? "R5" : "R4";
        else                                 tag = "R6";
      end else if (armed) begin
        tag = "R3";
      end
      chk({oe, io & mask} == {e_oe, e_io}, tag, {oe, io & mask}, {e_oe, e_io});
      sck = 1'b1;
      wait_n(3);
      chk({oe, io & mask} == {e_oe, e_io}, "R11", {oe, io & mask}, {e_oe, e_io});
      wait_n(3);
      sck = 1'b0;
      si = 1'($urandom);
      wait_n(6);
    end
    cs_n = 1'b1;
    wait_n(10);
    chk(handoff == 1'b1, "R8", {7'd0, handoff}, 8'h01);
    chk(oe == 4'b0000, "R8", {4'd0, oe}, 8'h00);
    if (!armed) chk(rd_cnt == rd0, idle_tag, 8'(rd_cnt - rd0), 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R6: watchdog expired, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    // serial, no wait, three whole bytes
    do_reset(1'b1);
    session(1'b1, 5, 0, 1'b0, 24, "R3");
    // spent: second assertion drives nothing
    session(1'b0, 5, 0, 1'b0, 16, "R9");
    // re-armed, quad with a short wait
    do_reset(1'b1);
    session(1'b1, 23'h12, 3, 1'b1, 13, "R3");
    // longest wait, serial, release mid-byte
    do_reset(1'b1);
    session(1'b1, 1, 255, 1'b0, 255 + 19, "R3");
    session(1'b0, 1, 0, 1'b0, 8, "R9");
    // quad across the top of the array
    do_reset(1'b1);
    session(1'b1, 23'h7FFF, 1, 1'b1, 1 + 2 * 514, "R3");
    // disabled
    do_reset(1'b0);
    session(1'b0, 3, 0, 1'b0, 16, "R1");
    // release during the wait
    do_reset(1'b1);
    session(1'b1, 2, 10, 1'b0, 4, "R3");
    session(1'b0, 2, 0, 1'b1, 4, "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule